// File: doc/BRIEF.md
# SGMII / Fiber Mode Autodetect Selector

This block decides whether a serial gigabit port runs in SGMII mode or in fiber mode (clause-37 auto-negotiation). When autodetect is off, a static strap input picks the mode. When autodetect is on, the selector bit of each received auto-negotiation page is compared with the current mode, and the mode flips if the bit does not match. Two sticky flags record events for software: a mode switch, and an SGMII-mode page that arrived with a fiber selector. Both flags clear on a one-cycle read-clear pulse.

While the port is in SGMII mode, each page with a valid SGMII selector is decoded into the link partner's link state, acknowledge, duplex and speed. These results are held on registered outputs. The auto-negotiation state machine that produces the pages and the register access path that reads the flags belong to neighbouring blocks.

Top module: `sgmii_mode_select`

## Requirements
- R1: While reset is asserted, `fiber_mode` equals `strap_fiber`, both sticky flags are 0, and `lp_link`, `lp_ack`, `lp_duplex` and `lp_speed` are all 0.
- R2: With `auto_en` low, `fiber_mode` takes the value of `strap_fiber` at each clock edge (0 = SGMII, 1 = fiber). Received pages never change the mode.
- R3: With `auto_en` high, a valid page whose bit 0 equals `fiber_mode` toggles the mode at that clock edge. SGMII expects bit 0 = 1 and fiber expects bit 0 = 0. A page that matches, and any change on `strap_fiber`, leaves the mode unchanged.
- R4: `mode_chg_flag` becomes 1 at the same edge at which `fiber_mode` changes value, whether the change comes from the strap or from autodetect.
- R5: `sel_mismatch_flag` becomes 1 when a valid page with bit 0 = 0 arrives while `fiber_mode` is 0. The same page in fiber mode does not set it.
- R6: A `flag_clr` pulse clears both sticky flags at the next edge. If a set event for a flag occurs at the same edge, that flag ends at 1.
- R7: A valid page arriving in SGMII mode with bit 0 = 1 updates the outputs as follows: `lp_link` from bit 15, `lp_ack` from bit 14, `lp_duplex` from bit 12, and `lp_speed` from bits 11:10 (00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s). Pages received in fiber mode, or with bit 0 = 0, leave these outputs unchanged.
- R8: Speed code 11 is reserved. A decoded page carrying it keeps the previous `lp_speed`, while link, acknowledge and duplex still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fiber | input | 1 | Static mode select: 0 = SGMII, 1 = fiber |
| auto_en | input | 1 | Enables selector-based mode autodetect |
| page_in | input | PAGE_W | Received auto-negotiation page |
| page_vld | input | 1 | One-cycle strobe marking `page_in` valid |
| flag_clr | input | 1 | Read-clear pulse for both sticky flags |
| fiber_mode | output | 1 | Current mode: 0 = SGMII, 1 = fiber |
| mode_chg_flag | output | 1 | Sticky: mode has switched |
| sel_mismatch_flag | output | 1 | Sticky: fiber selector seen in SGMII mode |
| lp_link | output | 1 | Partner link state (decoded) |
| lp_ack | output | 1 | Partner acknowledge (decoded) |
| lp_duplex | output | 1 | Partner duplex, 1 = full (decoded) |
| lp_speed | output | 2 | Partner speed code (decoded) |

## Verification
The bench builds the block with its default `PAGE_W` of 16. At this width the link, acknowledge, duplex and speed fields sit at their fixed positions at the top of the page, so every page pattern in the stimulus table is also a real SGMII page. With this width the table can reach mode toggles in both directions and strap changes that are ignored under autodetect. It can also reach a clear pulse that coincides with a set event, and a reserved speed code that arrives together with changing link bits.

// File: rtl/sgmii_mode_select.sv
module sgmii_mode_select #(
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_fiber,
  input  logic              auto_en,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              page_vld,
  input  logic              flag_clr,
  output logic              fiber_mode,
  output logic              mode_chg_flag,
  output logic              sel_mismatch_flag,
  output logic              lp_link,
  output logic              lp_ack,
  output logic              lp_duplex,
  output logic [1:0]        lp_speed
);
  localparam int LinkPos  = PAGE_W - 1;
  localparam int AckPos   = PAGE_W - 2;
  localparam int DupPos   = PAGE_W - 4;
  localparam int SpdHi    = PAGE_W - 5;
  localparam int SpdLo    = PAGE_W - 6;
  localparam logic [1:0] SpdReserved = 2'b11;

  logic sel_bit, wrong_sel, mode_nxt, mode_flip, mis_evt, decode_ok;

  assign sel_bit   = page_in[0];
  assign wrong_sel = page_vld && (sel_bit == fiber_mode);
  assign mode_nxt  = auto_en ? (fiber_mode ^ wrong_sel) : strap_fiber;
  assign mode_flip = mode_nxt != fiber_mode;
  assign mis_evt   = page_vld && !fiber_mode && !sel_bit;
  assign decode_ok = page_vld && !fiber_mode && sel_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiber_mode        <= strap_fiber;
      mode_chg_flag     <= 1'b0;
      sel_mismatch_flag <= 1'b0;
    end else begin
      fiber_mode        <= mode_nxt;
      mode_chg_flag     <= mode_flip | (mode_chg_flag & ~flag_clr);
      sel_mismatch_flag <= mis_evt | (sel_mismatch_flag & ~flag_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_link   <= 1'b0;
      lp_ack    <= 1'b0;
      lp_duplex <= 1'b0;
      lp_speed  <= 2'b00;
    end else if (decode_ok) begin
      lp_link   <= page_in[LinkPos];
      lp_ack    <= page_in[AckPos];
      lp_duplex <= page_in[DupPos];
      if (page_in[SpdHi:SpdLo] != SpdReserved)
        lp_speed <= page_in[SpdHi:SpdLo];
    end
  end

  assert_strap_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> fiber_mode == $past(strap_fiber));

  assert_auto_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && page_vld && page_in[0] == fiber_mode) |=> fiber_mode != $past(fiber_mode));

  assert_auto_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !(page_vld && page_in[0] == fiber_mode)) |=> $stable(fiber_mode));

  assert_chg_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fiber_mode != $past(fiber_mode)) |-> mode_chg_flag);

  assert_mismatch_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (page_vld && !fiber_mode && !page_in[0]) |=> sel_mismatch_flag);

  assert_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_mismatch_flag) |-> $past(flag_clr));

  assert_fiber_no_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fiber_mode |=> $stable(lp_link) && $stable(lp_duplex));

  assert_reserved_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (page_vld && !fiber_mode && page_in[0] && page_in[SpdHi:SpdLo] == SpdReserved)
      |=> $stable(lp_speed));
endmodule

// File: tb/tb_sgmii_mode_select.sv
module tb_sgmii_mode_select;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_fiber = 1'b0, auto_en = 1'b0, page_vld = 1'b0, flag_clr = 1'b0;
  logic [15:0] page_in = 16'h0000;
  logic fiber_mode, mode_chg_flag, sel_mismatch_flag, lp_link, lp_ack, lp_duplex;
  logic [1:0] lp_speed;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sgmii_mode_select #(.PAGE_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .strap_fiber(strap_fiber), .auto_en(auto_en),
    .page_in(page_in), .page_vld(page_vld), .flag_clr(flag_clr),
    .fiber_mode(fiber_mode), .mode_chg_flag(mode_chg_flag),
    .sel_mismatch_flag(sel_mismatch_flag), .lp_link(lp_link), .lp_ack(lp_ack),
    .lp_duplex(lp_duplex), .lp_speed(lp_speed));

  // inputs: auto, strap, vld, page, clr | expected: mode, chg, mis, link, ack, dup, speed
  localparam int NV = 18;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,16'hD401,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,2'b01}, // R7 decode
    {1'b0,1'b0,1'b1,16'h0000,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,2'b01}, // R5 R2
    {1'b0,1'b0,1'b0,16'h0000,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,2'b01}, // R6
    {1'b0,1'b1,1'b0,16'h0000,1'b0, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,2'b01}, // R2 R4
    {1'b0,1'b1,1'b1,16'hD401,1'b0, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,2'b01}, // R7 fiber ignore
    {1'b0,1'b1,1'b0,16'h0000,1'b1, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,2'b01}, // R6
    {1'b1,1'b1,1'b1,16'h0001,1'b0, 1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b01}, // R3 fiber->sgmii
    {1'b1,1'b1,1'b1,16'h8801,1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b10}, // R7 R3
    {1'b1,1'b0,1'b1,16'h0C01,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10}, // R8 R3
    {1'b1,1'b0,1'b1,16'h0000,1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b10}, // R3 R5
    {1'b1,1'b0,1'b1,16'h0000,1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b10}, // R3 R5
    {1'b1,1'b0,1'b1,16'h0001,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10}, // R6 R4
    {1'b1,1'b0,1'b0,16'h0000,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10}, // R6
    {1'b0,1'b1,1'b0,16'h0000,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10}, // R2 R4
    {1'b0,1'b1,1'b1,16'h0001,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10}, // R2
    {1'b0,1'b0,1'b1,16'h0000,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10}, // R6 R4
    {1'b0,1'b0,1'b1,16'h0000,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b10}, // R6 R5
    {1'b0,1'b0,1'b1,16'h5001,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'b00}  // R7
  };

  task automatic check(string req, logic [7:0] exp);
    logic [7:0] act;
    act = {fiber_mode, mode_chg_flag, sel_mismatch_flag, lp_link, lp_ack, lp_duplex, lp_speed};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1", 8'b0000_0000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", 8'b0000_0000);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {auto_en, strap_fiber, page_vld, page_in, flag_clr} = VEC[i][27:8];
      @(posedge clk);
      #1;
      check($sformatf("R2-R8 vector %0d", i), VEC[i][7:0]);
    end
    @(negedge clk);
    page_vld = 1'b0; flag_clr = 1'b0; auto_en = 1'b0; strap_fiber = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1 strap fiber", 8'b1000_0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release", 8'b1000_0000);
    @(negedge clk);
    auto_en = 1'b1; strap_fiber = 1'b0;
    @(posedge clk);
    #1;
    check("R3 strap ignored", 8'b1000_0000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule